// File: doc/BRIEF.md
# Picture-Raster Tile Scheduler

This block lets a single-core decoder consume a stream coded in tile order while it walks the coding tree blocks (CTBs) of a picture in whole-picture raster order. It is given the tile grid (the number of tile columns and rows, each column width and row height in CTBs), the pointer where payload data begins after the slice header, and one entry-point offset for each tile after the first. From these it issues a stream of commands to the entropy decoder.

Each command names one action. It may ask the decoder to decode one CTB, to start a fresh entropy state at a tile's first CTB, to store the state of the tile it is leaving, or to reload the stored state of a tile it is coming back to. For every tile column, a small store keeps the context handle and the bitstream read pointer that the decoder reported at its last save.

Commands leave on a valid/ready channel. The scheduler holds a command unchanged until the decoder takes it, and it never withdraws one. After a store command, the decoder hands back its read pointer and context handle on a second valid/ready channel. The scheduler waits for that report before it issues anything further. The configuration pins are plain levels and must stay steady while `busy` is high. Column widths and row heights must be at least 1. The column and row counts run from 1 to their maxima.

Top module: `tile_raster_sched`

## Requirements
- R1: A `start` pulse while idle begins one picture pass. `busy` stays high until `done`. `done` is high for exactly one cycle, after which the block is idle. `cmd_valid` is only high while `busy` is high.
- R2: While `cmd_valid` is high and `cmd_ready` is low, every command field holds its value and `cmd_valid` stays high. A command counts as taken only on a cycle where both are high.
- R3: The decode commands (`cmd_op` = 0) cover every CTB exactly once. They run through picture rows from top to bottom and, within a row, from left to right. `cmd_ctb` gives the tile-scan address of the CTB: tiles are numbered in raster order, CTBs are numbered in raster order inside each tile, and numbering starts at 0. For example, with a first tile 4 CTBs wide and 3 tall, the fifth decode carries address 12.
- R4: Every command's `cmd_tile` equals tile_row × columns + tile_column for the tile it concerns.
- R5: On the first CTB row of each tile, an init command (`cmd_op` = 1) comes before that tile's decodes. Its `cmd_ptr` is `cfg_hdr_end` for tile 0 and `cfg_hdr_end` plus offset k−1 for tile k (modulo 2^PTR_W). Its `cmd_ctx` is 0. Offset k−1 occupies bits [(k−1)·PTR_W +: PTR_W] of `cfg_entry_ofs`.
- R6: A save command (`cmd_op` = 2) follows the last decode of a tile's segment on a row when two conditions hold: the tile still has rows below it, and there is more than one column. Its `cmd_ptr`, `cmd_ctx` and `cmd_ctb` are 0. Non-decode commands carry `cmd_ctb` = 0.
- R7: After a save is taken, `cmd_valid` stays low until a save report is taken (`sv_valid` and `sv_ready` both high). `sv_ready` is high only during that wait.
- R8: When a tile is re-entered on a later row, a restore command (`cmd_op` = 3) comes before its decodes. It carries the `sv_ptr` and `sv_ctx` values that were reported for that tile's most recent save.
- R9: With a single tile column, no save or restore command is issued. Decoding of a tile continues from row to row without interruption.
- R10: On entering a new tile row, all stored column states are discarded. Each tile of that row starts with an init command, and a restore is never issued for a tile that has not been saved during the current pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a picture pass (sampled while idle) |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| cfg_cols | input | NC_W | Number of tile columns, 1..MAX_COLS |
| cfg_rows | input | NR_W | Number of tile rows, 1..MAX_ROWS |
| cfg_col_w | input | MAX_COLS·DIM_W | Column widths in CTBs, column i at [i·DIM_W +: DIM_W] |
| cfg_row_h | input | MAX_ROWS·DIM_W | Row heights in CTBs, row j at [j·DIM_W +: DIM_W] |
| cfg_hdr_end | input | PTR_W | Start of tile 0 payload |
| cfg_entry_ofs | input | (MAX_TILES−1)·PTR_W | Entry offsets of tiles 1..MAX_TILES−1 |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Decoder takes the command |
| cmd_op | output | 2 | 0 decode, 1 init, 2 save, 3 restore |
| cmd_tile | output | TILE_W | Tile raster index |
| cmd_ctb | output | ADDR_W | Tile-scan CTB address (decode only) |
| cmd_ptr | output | PTR_W | Read pointer for init and restore |
| cmd_ctx | output | CTX_W | Context handle for restore |
| sv_valid | input | 1 | Save report offered |
| sv_ready | output | 1 | Scheduler waits for a save report |
| sv_ptr | input | PTR_W | Read pointer at the save |
| sv_ctx | input | CTX_W | Context handle at the save |

## Verification
The bench builds the block with its defaults: a grid of up to 4×4 tiles, edges of 5-bit CTB counts, 24-bit pointers and 8-bit handles. It exercises every column and row count from 1 to 4, with edges of 1 to 8 CTBs. A 4×4 grid fills every slot of the per-column store and every entry offset. Single-column and single-tile pictures reach the paths that issue no save or restore. Several tile rows per picture exercise the discard and re-init at each tile-row boundary.

// File: rtl/trs_pkg.sv
package trs_pkg;
  typedef enum logic [1:0] {
    OP_DECODE  = 2'd0,
    OP_INIT    = 2'd1,
    OP_SAVE    = 2'd2,
    OP_RESTORE = 2'd3
  } op_e;
endpackage

// File: rtl/tile_geom.sv
// Grid arithmetic: segment bounds, tile-scan CTB address, tile index, entry pointer.
module tile_geom #(
  parameter int MAX_COLS = 4,
  parameter int MAX_ROWS = 4,
  parameter int DIM_W    = 5,
  parameter int PTR_W    = 24,
  parameter int NC_W     = 3,
  parameter int NR_W     = 3,
  parameter int TX_W     = 2,
  parameter int TY_W     = 2,
  parameter int PD_W     = 7,
  parameter int ADDR_W   = 14,
  parameter int TILE_W   = 4,
  localparam int MAX_TILES = MAX_COLS * MAX_ROWS
) (
  input  logic [NC_W-1:0]                  cfg_cols,
  input  logic [NR_W-1:0]                  cfg_rows,
  input  logic [MAX_COLS*DIM_W-1:0]        cfg_col_w,
  input  logic [MAX_ROWS*DIM_W-1:0]        cfg_row_h,
  input  logic [PTR_W-1:0]                 cfg_hdr_end,
  input  logic [(MAX_TILES-1)*PTR_W-1:0]   cfg_entry_ofs,
  input  logic [TX_W-1:0]                  tx,
  input  logic [TY_W-1:0]                  ty,
  input  logic [PD_W-1:0]                  y,
  input  logic [DIM_W-1:0]                 xx,
  output logic [DIM_W-1:0]                 seg_w,
  output logic [PD_W-1:0]                  row_first,
  output logic [PD_W-1:0]                  row_last,
  output logic [PD_W-1:0]                  pic_last,
  output logic [ADDR_W-1:0]                ctb,
  output logic [TILE_W-1:0]                tile,
  output logic [PTR_W-1:0]                 entry_ptr
);
  logic [PD_W-1:0]  cs, pw, rs, ph;
  logic [DIM_W-1:0] rh;
  logic [PTR_W-1:0] ofs_sel;

  always_comb begin
    cs = '0; pw = '0; seg_w = '0;
    for (int i = 0; i < MAX_COLS; i++) begin
      if (i < int'(tx))       cs = cs + PD_W'(cfg_col_w[i*DIM_W +: DIM_W]);
      if (i < int'(cfg_cols)) pw = pw + PD_W'(cfg_col_w[i*DIM_W +: DIM_W]);
      if (i == int'(tx))      seg_w = cfg_col_w[i*DIM_W +: DIM_W];
    end
  end

  always_comb begin
    rs = '0; ph = '0; rh = '0;
    for (int j = 0; j < MAX_ROWS; j++) begin
      if (j < int'(ty))       rs = rs + PD_W'(cfg_row_h[j*DIM_W +: DIM_W]);
      if (j < int'(cfg_rows)) ph = ph + PD_W'(cfg_row_h[j*DIM_W +: DIM_W]);
      if (j == int'(ty))      rh = cfg_row_h[j*DIM_W +: DIM_W];
    end
  end

  assign row_first = rs;
  assign row_last  = rs + PD_W'(rh) - PD_W'(1);
  assign pic_last  = ph - PD_W'(1);

  // Tiles above, tiles to the left in this tile row, rows above in this tile, then x.
  assign ctb = ADDR_W'(pw) * ADDR_W'(rs)
             + ADDR_W'(rh) * ADDR_W'(cs)
             + ADDR_W'(y - rs) * ADDR_W'(seg_w)
             + ADDR_W'(xx);

  assign tile = TILE_W'(int'(ty) * int'(cfg_cols) + int'(tx));

  always_comb begin
    ofs_sel = '0;
    for (int k = 1; k < MAX_TILES; k++)
      if (int'(tile) == k) ofs_sel = cfg_entry_ofs[(k-1)*PTR_W +: PTR_W];
  end

  assign entry_ptr = cfg_hdr_end + ofs_sel;
endmodule

// File: rtl/col_ctx_store.sv
// One saved read pointer and context handle per tile column.
module col_ctx_store #(
  parameter int MAX_COLS = 4,
  parameter int TX_W     = 2,
  parameter int PTR_W    = 24,
  parameter int CTX_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [TX_W-1:0]  wr_col,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [CTX_W-1:0] wr_ctx,
  input  logic [TX_W-1:0]  rd_col,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CTX_W-1:0] rd_ctx
);
  logic [PTR_W-1:0] ptr_q [MAX_COLS];
  logic [CTX_W-1:0] ctx_q [MAX_COLS];
  logic [MAX_COLS-1:0] ok_q;

  for (genvar g = 0; g < MAX_COLS; g++) begin : g_col
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ok_q[g]  <= 1'b0;
        ptr_q[g] <= '0;
        ctx_q[g] <= '0;
      end else if (clr) begin
        ok_q[g]  <= 1'b0;
      end else if (wr_en && wr_col == TX_W'(g)) begin
        ok_q[g]  <= 1'b1;
        ptr_q[g] <= wr_ptr;
        ctx_q[g] <= wr_ctx;
      end
    end
  end

  always_comb begin
    rd_ptr = '0;
    rd_ctx = '0;
    for (int i = 0; i < MAX_COLS; i++)
      if (rd_col == TX_W'(i) && ok_q[i]) begin
        rd_ptr = ptr_q[i];
        rd_ctx = ctx_q[i];
      end
  end
endmodule

// File: rtl/tile_raster_sched.sv
module tile_raster_sched #(
  parameter int MAX_COLS = 4,
  parameter int MAX_ROWS = 4,
  parameter int DIM_W    = 5,
  parameter int PTR_W    = 24,
  parameter int CTX_W    = 8,
  localparam int MAX_TILES = MAX_COLS * MAX_ROWS,
  localparam int NC_W   = $clog2(MAX_COLS + 1),
  localparam int NR_W   = $clog2(MAX_ROWS + 1),
  localparam int TX_W   = $clog2(MAX_COLS),
  localparam int TY_W   = $clog2(MAX_ROWS),
  localparam int TILE_W = $clog2(MAX_TILES),
  localparam int PD_W   = DIM_W + $clog2(MAX_COLS > MAX_ROWS ? MAX_COLS : MAX_ROWS),
  localparam int ADDR_W = 2 * PD_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  output logic                            busy,
  output logic                            done,
  input  logic [NC_W-1:0]                 cfg_cols,
  input  logic [NR_W-1:0]                 cfg_rows,
  input  logic [MAX_COLS*DIM_W-1:0]       cfg_col_w,
  input  logic [MAX_ROWS*DIM_W-1:0]       cfg_row_h,
  input  logic [PTR_W-1:0]                cfg_hdr_end,
  input  logic [(MAX_TILES-1)*PTR_W-1:0]  cfg_entry_ofs,
  output logic                            cmd_valid,
  input  logic                            cmd_ready,
  output logic [1:0]                      cmd_op,
  output logic [TILE_W-1:0]               cmd_tile,
  output logic [ADDR_W-1:0]               cmd_ctb,
  output logic [PTR_W-1:0]                cmd_ptr,
  output logic [CTX_W-1:0]                cmd_ctx,
  input  logic                            sv_valid,
  output logic                            sv_ready,
  input  logic [PTR_W-1:0]                sv_ptr,
  input  logic [CTX_W-1:0]                sv_ctx
);
  import trs_pkg::*;

  typedef enum logic [2:0] {
    S_IDLE, S_OPEN, S_ENTRY, S_DEC, S_SAVE, S_WAIT, S_NEXT, S_DONE
  } st_e;

  st_e               st;
  logic [PD_W-1:0]   y;
  logic [TX_W-1:0]   tx;
  logic [TY_W-1:0]   ty;
  logic [DIM_W-1:0]  xx;
  logic [TILE_W-1:0] prev_tile;
  logic              prev_ok;
  op_e               ent_op;

  logic [DIM_W-1:0]  seg_w;
  logic [PD_W-1:0]   row_first, row_last, pic_last;
  logic [ADDR_W-1:0] ctb;
  logic [TILE_W-1:0] tile;
  logic [PTR_W-1:0]  entry_ptr, rd_ptr;
  logic [CTX_W-1:0]  rd_ctx;
  logic              last_col, multi_col, store_clr, store_wr;

  tile_geom #(
    .MAX_COLS(MAX_COLS), .MAX_ROWS(MAX_ROWS), .DIM_W(DIM_W), .PTR_W(PTR_W),
    .NC_W(NC_W), .NR_W(NR_W), .TX_W(TX_W), .TY_W(TY_W), .PD_W(PD_W),
    .ADDR_W(ADDR_W), .TILE_W(TILE_W)
  ) u_geom (
    .cfg_cols(cfg_cols), .cfg_rows(cfg_rows), .cfg_col_w(cfg_col_w),
    .cfg_row_h(cfg_row_h), .cfg_hdr_end(cfg_hdr_end), .cfg_entry_ofs(cfg_entry_ofs),
    .tx(tx), .ty(ty), .y(y), .xx(xx),
    .seg_w(seg_w), .row_first(row_first), .row_last(row_last), .pic_last(pic_last),
    .ctb(ctb), .tile(tile), .entry_ptr(entry_ptr)
  );

  assign last_col  = (int'(tx) == int'(cfg_cols) - 1);
  assign multi_col = (int'(cfg_cols) > 1);
  assign store_clr = (st == S_IDLE && start) || (st == S_NEXT && last_col && y == row_last);
  assign store_wr  = (st == S_WAIT) && sv_valid;

  col_ctx_store #(
    .MAX_COLS(MAX_COLS), .TX_W(TX_W), .PTR_W(PTR_W), .CTX_W(CTX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .clr(store_clr), .wr_en(store_wr), .wr_col(tx),
    .wr_ptr(sv_ptr), .wr_ctx(sv_ctx), .rd_col(tx), .rd_ptr(rd_ptr), .rd_ctx(rd_ctx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      y         <= '0;
      tx        <= '0;
      ty        <= '0;
      xx        <= '0;
      prev_tile <= '0;
      prev_ok   <= 1'b0;
      ent_op    <= OP_INIT;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          y       <= '0;
          tx      <= '0;
          ty      <= '0;
          xx      <= '0;
          prev_ok <= 1'b0;
          st      <= S_OPEN;
        end
        S_OPEN: begin
          if (y == row_first) begin
            ent_op <= OP_INIT;
            st     <= S_ENTRY;
          end else if (!(prev_ok && prev_tile == tile)) begin
            ent_op <= OP_RESTORE;
            st     <= S_ENTRY;
          end else begin
            st <= S_DEC;
          end
        end
        S_ENTRY: if (cmd_ready) st <= S_DEC;
        S_DEC: if (cmd_ready) begin
          if (xx == seg_w - DIM_W'(1)) begin
            st <= (y != row_last && multi_col) ? S_SAVE : S_NEXT;
          end else begin
            xx <= xx + DIM_W'(1);
          end
        end
        S_SAVE: if (cmd_ready) st <= S_WAIT;
        S_WAIT: if (sv_valid) st <= S_NEXT;
        S_NEXT: begin
          prev_tile <= tile;
          prev_ok   <= 1'b1;
          xx        <= '0;
          if (last_col) begin
            tx <= '0;
            if (y == pic_last) begin
              st <= S_DONE;
            end else begin
              y <= y + PD_W'(1);
              if (y == row_last) ty <= ty + TY_W'(1);
              st <= S_OPEN;
            end
          end else begin
            tx <= tx + TX_W'(1);
            st <= S_OPEN;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_valid = (st == S_ENTRY) || (st == S_DEC) || (st == S_SAVE);
    cmd_tile  = tile;
    cmd_ctb   = '0;
    cmd_ptr   = '0;
    cmd_ctx   = '0;
    cmd_op    = OP_DECODE;
    case (st)
      S_ENTRY: begin
        cmd_op = ent_op;
        if (ent_op == OP_RESTORE) begin
          cmd_ptr = rd_ptr;
          cmd_ctx = rd_ctx;
        end else begin
          cmd_ptr = entry_ptr;
        end
      end
      S_DEC:  cmd_ctb = ctb;
      S_SAVE: cmd_op = OP_SAVE;
      default: ;
    endcase
  end

  assign sv_ready = (st == S_WAIT);
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
endmodule

// File: rtl/trs_chk.sv
module trs_chk #(
  parameter int MAX_TILES = 16,
  parameter int NC_W   = 3,
  parameter int NR_W   = 3,
  parameter int TILE_W = 4,
  parameter int ADDR_W = 14,
  parameter int PTR_W  = 24,
  parameter int CTX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [NC_W-1:0]   cfg_cols,
  input logic [NR_W-1:0]   cfg_rows,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [TILE_W-1:0] cmd_tile,
  input logic [ADDR_W-1:0] cmd_ctb,
  input logic [PTR_W-1:0]  cmd_ptr,
  input logic [CTX_W-1:0]  cmd_ctx,
  input logic              sv_valid,
  input logic              sv_ready
);
  logic                 pend;
  logic [MAX_TILES-1:0] saved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      saved <= '0;
    end else begin
      if (cmd_valid && cmd_ready && cmd_op == 2'd2) pend <= 1'b1;
      else if (sv_valid && sv_ready)                pend <= 1'b0;
      if (start && !busy) saved <= '0;
      else if (cmd_valid && cmd_ready && cmd_op == 2'd2) saved[cmd_tile] <= 1'b1;
    end
  end

  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !done);
  // R1
  cmd_in_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);
  // R2
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_tile)
      && $stable(cmd_ctb) && $stable(cmd_ptr) && $stable(cmd_ctx));
  // R4
  tile_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> int'(cmd_tile) < int'(cfg_cols) * int'(cfg_rows));
  // R7
  save_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !cmd_valid);
  // R7
  report_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sv_ready |-> pend);
  // R9
  save_multi_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op[1] |-> int'(cfg_cols) > 1);
  // R10
  restore_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd3 |-> saved[cmd_tile]);
endmodule

bind tile_raster_sched trs_chk #(
  .MAX_TILES(MAX_TILES), .NC_W(NC_W), .NR_W(NR_W), .TILE_W(TILE_W),
  .ADDR_W(ADDR_W), .PTR_W(PTR_W), .CTX_W(CTX_W)
) u_trs_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cfg_cols(cfg_cols), .cfg_rows(cfg_rows), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_tile(cmd_tile), .cmd_ctb(cmd_ctb),
  .cmd_ptr(cmd_ptr), .cmd_ctx(cmd_ctx), .sv_valid(sv_valid), .sv_ready(sv_ready)
);

// File: tb/test_tile_raster_sched.sv
module test_tile_raster_sched;
  localparam int MC = 4, MR = 4, DW = 5, PW = 24, CW = 8;
  localparam int MT = MC * MR;
  localparam int NEXP = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done;
  logic [2:0] cfg_cols = 3'd1;
  logic [2:0] cfg_rows = 3'd1;
  logic [MC*DW-1:0] cfg_col_w = '0;
  logic [MR*DW-1:0] cfg_row_h = '0;
  logic [PW-1:0] cfg_hdr_end = '0;
  logic [(MT-1)*PW-1:0] cfg_entry_ofs = '0;
  logic cmd_valid;
  logic cmd_ready = 1'b0;
  logic [1:0] cmd_op;
  logic [3:0] cmd_tile;
  logic [13:0] cmd_ctb;
  logic [PW-1:0] cmd_ptr;
  logic [CW-1:0] cmd_ctx;
  logic sv_valid = 1'b0;
  logic sv_ready;
  logic [PW-1:0] sv_ptr = '0;
  logic [CW-1:0] sv_ctx = '0;

  always #5 clk = ~clk;

  tile_raster_sched i_tile_raster_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .cfg_cols(cfg_cols), .cfg_rows(cfg_rows), .cfg_col_w(cfg_col_w), .cfg_row_h(cfg_row_h),
    .cfg_hdr_end(cfg_hdr_end), .cfg_entry_ofs(cfg_entry_ofs),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_tile(cmd_tile),
    .cmd_ctb(cmd_ctb), .cmd_ptr(cmd_ptr), .cmd_ctx(cmd_ctx),
    .sv_valid(sv_valid), .sv_ready(sv_ready), .sv_ptr(sv_ptr), .sv_ctx(sv_ctx)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  int C, R, cw[MC], rh[MR];
  int hdr, ofs[MT];
  int e_op[NEXP], e_tile[NEXP], e_ctb[NEXP], e_ptr[NEXP], e_ctx[NEXP];
  int ne;
  int tmap[4096];
  int scnt[MT];
  int n_dec, n_sr, n_init, fifth_ctb;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int spt(int t, int k);
    return (24'h100000 + t * 256 + k) & 24'hFFFFFF;
  endfunction
  function automatic int sctx(int t, int k);
    return (t * 16 + k) & 255;
  endfunction

  task automatic push(int op, int t, int c, int p, int x);
    e_op[ne] = op; e_tile[ne] = t; e_ctb[ne] = c; e_ptr[ne] = p; e_ctx[ne] = x;
    ne++;
  endtask

  task automatic build_exp();
    int cs[MC], rs[MR];
    int n, acc;
    acc = 0;
    for (int i = 0; i < C; i++) begin cs[i] = acc; acc += cw[i]; end
    acc = 0;
    for (int j = 0; j < R; j++) begin rs[j] = acc; acc += rh[j]; end
    n = 0;
    for (int j = 0; j < R; j++)
      for (int i = 0; i < C; i++)
        for (int a = 0; a < rh[j]; a++)
          for (int b = 0; b < cw[i]; b++) begin
            tmap[(rs[j] + a) * 64 + cs[i] + b] = n;
            n++;
          end
    ne = 0;
    for (int j = 0; j < R; j++)
      for (int a = 0; a < rh[j]; a++)
        for (int i = 0; i < C; i++) begin
          int t;
          t = j * C + i;
          if (a == 0)
            push(1, t, 0, (t == 0) ? hdr : ((hdr + ofs[t]) & 24'hFFFFFF), 0);
          else if (C > 1)
            push(3, t, 0, spt(t, a - 1), sctx(t, a - 1));
          for (int b = 0; b < cw[i]; b++) push(0, t, tmap[(rs[j] + a) * 64 + cs[i] + b], 0, 0);
          if (a != rh[j] - 1 && C > 1) push(2, t, 0, 0, 0);
        end
  endtask

  task automatic apply_cfg();
    cfg_cols = 3'(C);
    cfg_rows = 3'(R);
    cfg_col_w = '0;
    cfg_row_h = '0;
    for (int i = 0; i < MC; i++) cfg_col_w[i*DW +: DW] = DW'((i < C) ? cw[i] : 0);
    for (int j = 0; j < MR; j++) cfg_row_h[j*DW +: DW] = DW'((j < R) ? rh[j] : 0);
    cfg_hdr_end = PW'(hdr);
    for (int k = 1; k < MT; k++) cfg_entry_ofs[(k-1)*PW +: PW] = PW'(ofs[k]);
  endtask

  function automatic string rq(int op);
    case (op)
      0: return "R3";
      1: return "R5";
      2: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic run_pic();
    int got, dly, stile, limit;
    bit fin, pend, fire, held;
    int h_op, h_tile, h_ctb, h_ptr, h_ctx;
    apply_cfg();
    build_exp();
    for (int t = 0; t < MT; t++) scnt[t] = 0;
    n_dec = 0; n_sr = 0; n_init = 0; fifth_ctb = -1;
    got = 0; fin = 0; pend = 0; fire = 0; held = 0; dly = 0; stile = 0;
    h_op = 0; h_tile = 0; h_ctb = 0; h_ptr = 0; h_ctx = 0;
    limit = cyc + 20000;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R1", "busy after start", busy, 1);
    while (!fin) begin
      if (cyc > limit || cyc > 190000) begin
        chk(1'b0, "R1", "watchdog expired", cyc, limit);
        fin = 1;
      end else begin
        if (fire) begin sv_valid = 1'b0; fire = 0; end
        if (pend) begin
          chk(!cmd_valid, "R7", "command during save wait", cmd_valid, 0);
          if (!sv_valid) begin
            if (dly == 0) begin
              sv_valid = 1'b1;
              sv_ptr = PW'(spt(stile, scnt[stile]));
              sv_ctx = CW'(sctx(stile, scnt[stile]));
              scnt[stile]++;
            end else dly--;
          end
          if (sv_valid && sv_ready) begin fire = 1; pend = 0; end
        end else begin
          chk(!sv_ready, "R7", "sv_ready outside wait", sv_ready, 0);
        end
        if (held) begin
          chk(cmd_valid && int'(cmd_op) == h_op && int'(cmd_tile) == h_tile &&
              int'(cmd_ctb) == h_ctb && int'(cmd_ptr) == h_ptr && int'(cmd_ctx) == h_ctx,
              "R2", "held command changed", {cmd_valid, cmd_op, cmd_tile}, {1'b1, 2'(h_op), 4'(h_tile)});
          held = 0;
        end
        cmd_ready = ($urandom % 4) != 0;
        if (cmd_valid && cmd_ready) begin
          if (got < ne) begin
            chk(int'(cmd_op) == e_op[got], rq(e_op[got]), "op", cmd_op, e_op[got]);
            chk(int'(cmd_tile) == e_tile[got], "R4", "tile index", cmd_tile, e_tile[got]);
            chk(int'(cmd_ctb) == e_ctb[got] && int'(cmd_ptr) == e_ptr[got] && int'(cmd_ctx) == e_ctx[got],
                rq(e_op[got]), "ctb/ptr/ctx", {cmd_ctb, cmd_ptr, cmd_ctx},
                {14'(e_ctb[got]), 24'(e_ptr[got]), 8'(e_ctx[got])});
          end else begin
            chk(1'b0, "R3", "surplus command", got, ne);
          end
          if (cmd_op == 2'd0) begin
            n_dec++;
            if (n_dec == 5) fifth_ctb = int'(cmd_ctb);
          end
          if (cmd_op[1] && cmd_op != 2'd0) n_sr += (cmd_op == 2'd2 || cmd_op == 2'd3) ? 1 : 0;
          if (cmd_op == 2'd1) n_init++;
          if (cmd_op == 2'd2) begin pend = 1; dly = $urandom % 4; stile = int'(cmd_tile); end
          got++;
        end else if (cmd_valid) begin
          held = 1;
          h_op = int'(cmd_op); h_tile = int'(cmd_tile); h_ctb = int'(cmd_ctb);
          h_ptr = int'(cmd_ptr); h_ctx = int'(cmd_ctx);
        end
        if (done) fin = 1;
        @(negedge clk);
      end
    end
    cmd_ready = 1'b0;
    chk(got == ne, "R3", "command count", got, ne);
    chk(n_init == C * R, "R10", "init count", n_init, C * R);
    chk(!busy && !done, "R1", "idle after done", {busy, done}, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < MT; k++) ofs[k] = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cmd_valid && !sv_ready, "R1", "reset state",
        {busy, done, cmd_valid, sv_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: first tile 4 wide and 3 tall; fifth decode jumps to tile 1.
    C = 3; R = 2; cw[0] = 4; cw[1] = 6; cw[2] = 3; rh[0] = 3; rh[1] = 1;
    hdr = 100; for (int k = 1; k < MT; k++) ofs[k] = k * 1000;
    run_pic();
    chk(fifth_ctb == 12, "R3", "fifth decode address", fifth_ctb, 12);

    // Directed: single column, several rows.
    C = 1; R = 3; cw[0] = 5; rh[0] = 2; rh[1] = 3; rh[2] = 1;
    run_pic();
    chk(n_sr == 0, "R9", "save/restore with one column", n_sr, 0);

    // Directed: one CTB picture.
    C = 1; R = 1; cw[0] = 1; rh[0] = 1; hdr = 24'hFFFFF0;
    run_pic();

    // Directed: full 4x4 grid with wrapping pointers.
    C = 4; R = 4;
    for (int i = 0; i < 4; i++) begin cw[i] = i + 1; rh[i] = 4 - i; end
    hdr = 24'hFFFF00; for (int k = 1; k < MT; k++) ofs[k] = 24'hF0 + k * 3;
    run_pic();

    // Random grids.
    for (int p = 0; p < 25; p++) begin
      C = 1 + $urandom % 4; R = 1 + $urandom % 4;
      for (int i = 0; i < MC; i++) cw[i] = 1 + $urandom % 8;
      for (int j = 0; j < MR; j++) rh[j] = 1 + $urandom % 6;
      hdr = $urandom % (1 << 24);
      for (int k = 1; k < MT; k++) ofs[k] = $urandom % (1 << 24);
      run_pic();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule